// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block turns one request for a multiple-register load or store into a stream of single-word transfers. A request carries a base address, a 16-bit register mask, a 2-bit addressing mode and a writeback enable. The block accepts the request while it is idle. It then issues one beat per clock cycle. Each beat carries a word address and the index of the register that moves on that beat. After the last beat it pulses a done flag together with the updated base value.

Registers always go out in ascending index order, and the lowest index always lands on the lowest address. The mode only decides where the address window sits relative to the base. The two "after" modes put the base at the bottom or top of the window. The two "before" modes step one word past the base first. This covers all four stack styles. Pushing with decrement-before and popping with increment-after from the written-back pointer gives a full descending stack. Decrement-after and increment-before give the empty and ascending variants. Memory and the register file sit outside the block.

Top module: `blkxfer_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `beat_valid_o`, `done_o` and `wb_valid_o` are all low.
- R2: A request on `start_i` is accepted only in a cycle where `busy_o` is low. A request or changed request inputs presented while `busy_o` is high has no effect on the beats, the done pulse or the writeback value of the transfer in progress, and starts no new transfer.
- R3: For a mask with N set bits, `beat_valid_o` is high for exactly N consecutive cycles, starting the cycle after acceptance. `beat_reg_o` presents the set bit positions in ascending order, and `busy_o` is high on every beat.
- R4: Within a transfer, each beat address is the previous beat address plus 4.
- R5: Mode code 0 (increment-after): the first beat address is the base.
- R6: Mode code 1 (increment-before): the first beat address is base+4.
- R7: Mode code 2 (decrement-after): the first beat address is base−4N+4.
- R8: Mode code 3 (decrement-before): the first beat address is base−4N.
- R9: `done_o` is high for exactly one cycle, the cycle right after the last beat, and never together with `beat_valid_o`. `busy_o` is low in the following cycle. All address arithmetic wraps modulo 2^32.
- R10: In the done cycle, `wb_valid_o` is high exactly when writeback was requested and N>0. `wb_addr_o` then equals base+4N for mode codes 0 and 1 and base−4N for codes 2 and 3. `wb_valid_o` is never high outside the done cycle.
- R11: An all-zero mask gives no beats, `done_o` in the cycle right after acceptance, and `wb_valid_o` low even with writeback requested.
- R12: A decrement-before store with writeback, followed by an increment-after load whose base is the returned `wb_addr_o` and whose mask is the same, moves every register at the same address in both transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request; accepted when busy_o is low |
| base_i | input | 32 | Base address of the request |
| list_i | input | 16 | Register mask, bit i selects register i |
| mode_i | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wb_en_i | input | 1 | Writeback of the updated base requested |
| busy_o | output | 1 | A transfer is in progress |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_addr_o | output | 32 | Word address of the current beat |
| beat_reg_o | output | 4 | Register index of the current beat |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Updated base is valid, with done_o |
| wb_addr_o | output | 32 | Updated base value |

## Verification
Two events can coincide: a new request on `start_i`, and the completion or beats of the transfer already running. This includes a request held high through the done cycle. The bench provokes this by keeping `start_i` high with different base, mask and mode values for a whole transfer. It then judges from the ports that the beat addresses, register indices, done pulse and writeback value all follow the originally accepted request, and that no extra transfer begins. Empty masks are also placed right after full ones, so that the immediate-completion path follows a long run.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'd0,
    MODE_INC_BEFORE = 2'd1,
    MODE_DEC_AFTER  = 2'd2,
    MODE_DEC_BEFORE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] count_o
);

  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) begin
      count_o = count_o + CW'(vec_i[i]);
    end
  end

endmodule

// File: rtl/lsm_pick.sv
module lsm_pick #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  rest_o
);

  logic [W-1:0] seen;
  logic [W-1:0] first;

  for (genvar i = 0; i < W; i++) begin : g_chain
    if (i == 0) begin : g_lsb
      assign seen[i]  = vec_i[i];
      assign first[i] = vec_i[i];
    end else begin : g_upper
      assign seen[i]  = seen[i-1] | vec_i[i];
      assign first[i] = vec_i[i] & ~seen[i-1];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) begin
        idx_o = idx_o | IW'(i);
      end
    end
  end

  assign rest_o = vec_i & ~first;

endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
  import lsm_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 5,
  parameter int STRIDE = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  xfer_mode_e    mode_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] wb_o
);

  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  logic [AW-1:0] span;

  assign span = AW'(count_i) * STEP;

  always_comb begin
    unique case (mode_i)
      MODE_INC_AFTER:  start_o = base_i;
      MODE_INC_BEFORE: start_o = base_i + STEP;
      MODE_DEC_AFTER:  start_o = base_i - span + STEP;
      default:         start_o = base_i - span;
    endcase
  end

  always_comb begin
    if (mode_i == MODE_DEC_AFTER || mode_i == MODE_DEC_BEFORE) begin
      wb_o = base_i - span;
    end else begin
      wb_o = base_i + span;
    end
  end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import lsm_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NREG   = 16,
  parameter int STRIDE = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [AW-1:0]           base_i,
  input  logic [NREG-1:0]         list_i,
  input  logic [1:0]              mode_i,
  input  logic                    wb_en_i,
  output logic                    busy_o,
  output logic                    beat_valid_o,
  output logic [AW-1:0]           beat_addr_o,
  output logic [$clog2(NREG)-1:0] beat_reg_o,
  output logic                    done_o,
  output logic                    wb_valid_o,
  output logic [AW-1:0]           wb_addr_o
);

  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign core_rst_n = rsync_q[1];

  // request decode
  logic [CW-1:0] req_count;
  logic [AW-1:0] plan_start;
  logic [AW-1:0] plan_wb;
  xfer_mode_e    req_mode;

  assign req_mode = xfer_mode_e'(mode_i);

  lsm_popcnt #(.W(NREG), .CW(CW)) u_popcnt (
    .vec_i   (list_i),
    .count_o (req_count)
  );

  lsm_addr_plan #(.AW(AW), .CW(CW), .STRIDE(STRIDE)) u_plan (
    .base_i  (base_i),
    .count_i (req_count),
    .mode_i  (req_mode),
    .start_o (plan_start),
    .wb_o    (plan_wb)
  );

  // sequencing state
  seq_state_e    state_q, state_d;
  logic [NREG-1:0] list_q, list_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] wb_q, wb_d;
  logic          wbv_q, wbv_d;
  logic [IW-1:0] pick_idx;
  logic [NREG-1:0] pick_rest;
  logic          accept;
  logic          walk_en;
  logic          req_empty;

  lsm_pick #(.W(NREG), .IW(IW)) u_pick (
    .vec_i  (list_q),
    .idx_o  (pick_idx),
    .rest_o (pick_rest)
  );

  assign accept    = (state_q == SEQ_IDLE) && start_i;
  assign walk_en   = (state_q == SEQ_RUN);
  assign req_empty = (req_count == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = req_empty ? SEQ_DONE : SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (pick_rest == '0) begin
          state_d = SEQ_DONE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    list_d = list_q;
    addr_d = addr_q;
    if (accept) begin
      list_d = list_i;
      addr_d = plan_start;
    end else if (walk_en) begin
      list_d = pick_rest;
      addr_d = addr_q + STEP;
    end
  end

  always_comb begin
    wb_d  = wb_q;
    wbv_d = wbv_q;
    if (accept) begin
      wb_d  = plan_wb;
      wbv_d = wb_en_i && !req_empty;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      list_q <= '0;
      addr_q <= '0;
    end else if (accept || walk_en) begin
      list_q <= list_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      wb_q  <= '0;
      wbv_q <= 1'b0;
    end else if (accept) begin
      wb_q  <= wb_d;
      wbv_q <= wbv_d;
    end
  end

  assign busy_o       = (state_q != SEQ_IDLE);
  assign beat_valid_o = walk_en;
  assign beat_addr_o  = addr_q;
  assign beat_reg_o   = pick_idx;
  assign done_o       = (state_q == SEQ_DONE);
  assign wb_valid_o   = done_o && wbv_q;
  assign wb_addr_o    = wb_q;

endmodule

// File: rtl/lsm_chk.sv
module lsm_chk #(
  parameter int AW     = 32,
  parameter int NREG   = 16,
  parameter int STRIDE = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy_o,
  input logic                    beat_valid_o,
  input logic [AW-1:0]           beat_addr_o,
  input logic [$clog2(NREG)-1:0] beat_reg_o,
  input logic                    done_o,
  input logic                    wb_valid_o
);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && $past(beat_valid_o)) |-> (beat_addr_o == $past(beat_addr_o) + AW'(STRIDE)));

  a_r3_reg_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && $past(beat_valid_o)) |-> (beat_reg_o > $past(beat_reg_o)));

  a_r3_beat_busy: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o |-> busy_o);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  a_r9_done_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !beat_valid_o);

  a_r10_wb_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o);

endmodule

bind blkxfer_seq lsm_chk #(.AW(AW), .NREG(NREG), .STRIDE(STRIDE)) u_lsm_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .beat_valid_o (beat_valid_o),
  .beat_addr_o  (beat_addr_o),
  .beat_reg_o   (beat_reg_o),
  .done_o       (done_o),
  .wb_valid_o   (wb_valid_o)
);

// File: tb/blkxfer_seq_bench.sv
`timescale 1ns/1ps
module blkxfer_seq_bench;

  localparam int NREG = 16;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [15:0] list_i;
  logic [1:0]  mode_i;
  logic        wb_en_i;
  logic        busy_o;
  logic        beat_valid_o;
  logic [31:0] beat_addr_o;
  logic [3:0]  beat_reg_o;
  logic        done_o;
  logic        wb_valid_o;
  logic [31:0] wb_addr_o;

  int n_chk;
  int n_bad;
  bit finished;
  logic [31:0] seen_addr [NREG];
  logic [31:0] last_wb;

  blkxfer_seq u_blkxfer_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .base_i       (base_i),
    .list_i       (list_i),
    .mode_i       (mode_i),
    .wb_en_i      (wb_en_i),
    .busy_o       (busy_o),
    .beat_valid_o (beat_valid_o),
    .beat_addr_o  (beat_addr_o),
    .beat_reg_o   (beat_reg_o),
    .done_o       (done_o),
    .wb_valid_o   (wb_valid_o),
    .wb_addr_o    (wb_addr_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int count_bits(input logic [15:0] l);
    int c = 0;
    for (int i = 0; i < NREG; i++) if (l[i]) c++;
    return c;
  endfunction

  function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [15:0] l,
                                            input logic [1:0] m);
    logic [31:0] span = 32'(count_bits(l)) * 32'd4;
    case (m)
      2'd0:    return b;
      2'd1:    return b + 32'd4;
      2'd2:    return b - span + 32'd4;
      default: return b - span;
    endcase
  endfunction

  function automatic logic [31:0] exp_wb(input logic [31:0] b, input logic [15:0] l,
                                         input logic [1:0] m);
    logic [31:0] span = 32'(count_bits(l)) * 32'd4;
    return m[1] ? b - span : b + span;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0:    return "R5";
      2'd1:    return "R6";
      2'd2:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic do_xfer(input logic [31:0] b, input logic [15:0] l, input logic [1:0] m,
                         input bit wb, input bit hold);
    logic [31:0] a;
    int n;
    bit first;
    n = count_bits(l);
    a = exp_first(b, l, m);
    first = 1'b1;
    @(negedge clk);
    start_i = 1'b1; base_i = b; list_i = l; mode_i = m; wb_en_i = wb;
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      base_i = ~b; list_i = ~l; mode_i = ~m; wb_en_i = ~wb;
    end else begin
      start_i = 1'b0;
    end
    for (int r = 0; r < NREG; r++) begin
      if (l[r]) begin
        check(beat_valid_o === 1'b1, "R3 beat valid", {31'd0, beat_valid_o}, 32'd1);
        check(busy_o === 1'b1, "R3 busy on beat", {31'd0, busy_o}, 32'd1);
        check(beat_reg_o === 4'(r), hold ? "R2 R3 beat register" : "R3 beat register",
              {28'd0, beat_reg_o}, 32'(r));
        check(beat_addr_o === a, first ? mode_tag(m) : "R4 beat address", beat_addr_o, a);
        seen_addr[r] = beat_addr_o;
        first = 1'b0;
        a = a + 32'd4;
        @(negedge clk);
      end
    end
    check(done_o === 1'b1, (n == 0) ? "R11 done after empty" : "R9 done after last",
          {31'd0, done_o}, 32'd1);
    check(beat_valid_o === 1'b0, (n == 0) ? "R11 no beat" : "R3 beat count",
          {31'd0, beat_valid_o}, 32'd0);
    check(wb_valid_o === (wb && n > 0), (n == 0) ? "R11 no writeback" : "R10 wb valid",
          {31'd0, wb_valid_o}, {31'd0, (wb && n > 0)});
    if (wb && n > 0) begin
      check(wb_addr_o === exp_wb(b, l, m), hold ? "R2 R10 wb value" : "R10 wb value",
            wb_addr_o, exp_wb(b, l, m));
    end
    last_wb = wb_addr_o;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o === 1'b0, "R9 done single cycle", {31'd0, done_o}, 32'd0);
    check(busy_o === 1'b0, hold ? "R2 no extra transfer" : "R9 idle after done",
          {31'd0, busy_o}, 32'd0);
    check(wb_valid_o === 1'b0, "R10 wb only in done", {31'd0, wb_valid_o}, 32'd0);
  endtask

  initial begin
    finished = 1'b0;
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pushed [NREG];
    logic [31:0] rb;
    logic [15:0] rl;
    n_chk = 0; n_bad = 0;
    void'($urandom(32'd51966));
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; list_i = '0; mode_i = '0; wb_en_i = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && beat_valid_o === 1'b0 && done_o === 1'b0 && wb_valid_o === 1'b0,
          "R1 in reset", {28'd0, busy_o, beat_valid_o, done_o, wb_valid_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o === 1'b0 && beat_valid_o === 1'b0 && done_o === 1'b0 && wb_valid_o === 1'b0,
          "R1 after release", {28'd0, busy_o, beat_valid_o, done_o, wb_valid_o}, 32'd0);

    // directed: every mode with a full mask, then sparse masks
    for (int m = 0; m < 4; m++) do_xfer(32'h0000_1000, 16'hFFFF, 2'(m), 1'b1, 1'b0);
    for (int m = 0; m < 4; m++) do_xfer(32'h0000_0200, 16'h8001, 2'(m), 1'b1, 1'b0);
    do_xfer(32'h0000_0040, 16'h0010, 2'd3, 1'b0, 1'b0);
    // empty mask right after a full one, with writeback requested
    do_xfer(32'h0000_3000, 16'hFFFF, 2'd1, 1'b1, 1'b0);
    do_xfer(32'h0000_3000, 16'h0000, 2'd3, 1'b1, 1'b0);
    do_xfer(32'h0000_3000, 16'h0000, 2'd0, 1'b1, 1'b1);
    // wrap below zero and above the top
    do_xfer(32'h0000_0008, 16'hFFFF, 2'd3, 1'b1, 1'b0);
    do_xfer(32'hFFFF_FFF8, 16'h00FF, 2'd1, 1'b1, 1'b1);

    // R12: full descending stack push then pop
    do_xfer(32'h0000_8000, 16'h40F3, 2'd3, 1'b1, 1'b0);
    for (int r = 0; r < NREG; r++) pushed[r] = seen_addr[r];
    rb = last_wb;
    do_xfer(rb, 16'h40F3, 2'd0, 1'b1, 1'b0);
    for (int r = 0; r < NREG; r++) begin
      if (r == 0 || r == 1 || (r >= 4 && r <= 7) || r == 14) begin
        check(seen_addr[r] === pushed[r], "R12 stack pop address", seen_addr[r], pushed[r]);
      end
    end
    check(last_wb === 32'h0000_8000, "R12 stack pointer restored", last_wb, 32'h0000_8000);

    // random transfers
    for (int k = 0; k < 80; k++) begin
      rb = $urandom;
      rl = 16'($urandom);
      if (k % 7 == 0) rl = 16'h0000;
      else if (k % 5 == 0) rl = 16'h0001 << ($urandom % 16);
      do_xfer({rb[31:2], 2'b00}, rl, 2'($urandom % 4), 1'($urandom), (k % 3) == 0);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule